// File: doc/BRIEF.md
# Secondary Packet Slot Store

The block holds a small set of secondary data packets that a video link transmitter sends during the blanking interval. Each packet is a 4-byte header followed by a 32-byte payload. Software picks a slot and writes the header as one 32-bit word and the payload as eight 32-bit words. These writes land in that slot's shadow copy. A commit then makes the shadow copy the active one, either at once or at the next frame boundary.

Each slot has two banks in one word-addressed RAM and a one-bit bank selector. A commit flips the selector, so the swap is atomic and takes one cycle. After a commit, software writes into the other bank. Because of this, a packet must be written in full before each commit.

One slot (parameter `TX_SLOT`, default 4) serves one-shot messages. A send control arms a single transmission of that slot's active copy. The launch happens either at the first blanking cycle or at a programmed line. The packet leaves as a byte stream under a valid/ready handshake. Status flags report deferred commits, pending sends, and software writes that collide with a transmission.

Top module: `sec_pkt_store`

## Requirements
- R1: After reset, `tx_valid`, `send_pending`, `conflict` and every bit of `imm_pending` and `frame_pending` are 0.
- R2: Header and payload writes to slot `TX_SLOT` do not change the transmitted packet until that slot is committed.
- R3: After an immediate commit of `TX_SLOT`, a send emits 36 bytes. The first four are the header word's bits 7:0, 15:8, 23:16 and 31:24. Then come payload words at index 0 to 7, each sent least significant byte first.
- R4: A frame-commit request sets `frame_pending[slot]`. That bit stays high, and the old packet is still sent, until a `frame_start` pulse. After the pulse the bit is 0 and the new packet is sent.
- R5: An immediate commit of `TX_SLOT` while that slot is being transmitted is deferred. `imm_pending[TX_SLOT]` stays high, and the bytes in flight are the old packet. The commit completes on the first cycle after the transmission ends, and the flag then drops.
- R6: `send_pending` rises when a send is armed and falls only after the 36th byte is accepted. While `tx_valid` is high and `tx_ready` is low, `tx_data` and `tx_valid` hold.
- R7: Writing the send control with the arm bit at 0 before launch cancels the send. `send_pending` falls, and no byte is emitted even when blanking follows.
- R8: With the any-line bit set, an armed send launches on the first cycle with `blank_active` high. It never launches while `blank_active` is low.
- R9: With the any-line bit clear, an armed send launches only in a cycle where `blank_active` is high and `line_cnt` equals the programmed line.
- R10: A header or payload write to `TX_SLOT` during its transmission sets `conflict`. A write to another slot does not set it. The flag stays set until a `sw_conflict_clr` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_slot | input | SLOT_W | Slot targeted by writes and commits |
| sw_hdr_we | input | 1 | Write `sw_wdata` as the header word |
| sw_pay_we | input | 1 | Write `sw_wdata` as payload word `sw_pay_idx` |
| sw_pay_idx | input | PIDX_W | Payload word index |
| sw_wdata | input | 32 | Write data |
| sw_imm_commit | input | 1 | Immediate commit strobe for `sw_slot` |
| sw_frame_commit | input | 1 | Frame-boundary commit request for `sw_slot` |
| sw_send_wr | input | 1 | Load the send control fields |
| sw_send_arm | input | 1 | Send arm bit (0 cancels) |
| sw_send_anyline | input | 1 | Launch at earliest blanking cycle |
| sw_send_line | input | LINE_W | Launch line when any-line is clear |
| sw_conflict_clr | input | 1 | Clear the conflict flag |
| frame_start | input | 1 | Frame boundary pulse |
| blank_active | input | 1 | Transmitter is in blanking |
| line_cnt | input | LINE_W | Current line number |
| tx_ready | input | 1 | Downstream accepts a byte |
| tx_data | output | 8 | Packet byte |
| tx_valid | output | 1 | `tx_data` is valid |
| send_pending | output | 1 | Send armed or in progress |
| imm_pending | output | NUM_SLOTS | Deferred immediate commit per slot |
| frame_pending | output | NUM_SLOTS | Frame commit waiting per slot |
| conflict | output | 1 | Write hit the slot under transmission |

## Verification
Two events can fall in the same cycle: the transmitter reading the active bank of `TX_SLOT`, and software committing or writing that same slot. The bench provokes this by starting a send and, partway through the byte stream, pulsing an immediate commit and a payload write to the slot being read. It judges the outcome three ways. The bytes in flight must be the old packet. `imm_pending` must stay high until one cycle after the last byte and then drop. `conflict` must rise only for the write that hit the busy slot. A following send must then carry the new packet.

// File: rtl/sec_pkt_pkg.sv
package sec_pkt_pkg;
  typedef enum logic [1:0] {
    TX_IDLE = 2'd0,
    TX_RD   = 2'd1,
    TX_LD   = 2'd2,
    TX_OUT  = 2'd3
  } tx_state_e;
endpackage

// File: rtl/sec_pkt_ram.sv
module sec_pkt_ram #(
  parameter int AW = 8,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [0:DEPTH-1];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/sec_pkt_commit.sv
module sec_pkt_commit #(
  parameter int NUM_SLOTS = 8,
  parameter int SLOT_W    = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [SLOT_W-1:0]    sel_slot,
  input  logic                 imm_req,
  input  logic                 frame_req,
  input  logic                 frame_start,
  input  logic                 rd_busy,
  input  logic [SLOT_W-1:0]    rd_slot,
  output logic [NUM_SLOTS-1:0] bank,
  output logic [NUM_SLOTS-1:0] imm_pend,
  output logic [NUM_SLOTS-1:0] frame_pend
);
  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    logic bank_r, imm_r, req_r, due_r;
    logic hit, reading, want_imm, want_frm;

    assign hit      = (sel_slot == SLOT_W'(s));
    assign reading  = rd_busy && (rd_slot == SLOT_W'(s));
    assign want_imm = (imm_req && hit) || imm_r;
    assign want_frm = (frame_start && req_r) || due_r;

    always_ff @(posedge clk) begin
      if (rst) begin
        bank_r <= 1'b0;
        imm_r  <= 1'b0;
        req_r  <= 1'b0;
        due_r  <= 1'b0;
      end else begin
        // a request raised in the same cycle as a boundary waits for the next one
        req_r <= (frame_start ? 1'b0 : req_r) | (frame_req && hit);
        if ((want_imm || want_frm) && !reading) begin
          bank_r <= ~bank_r;
          imm_r  <= 1'b0;
          due_r  <= 1'b0;
        end else begin
          imm_r  <= want_imm;
          due_r  <= want_frm;
        end
      end
    end

    assign bank[s]       = bank_r;
    assign imm_pend[s]   = imm_r;
    assign frame_pend[s] = req_r | due_r;
  end
endmodule

// File: rtl/sec_pkt_tx.sv
module sec_pkt_tx
  import sec_pkt_pkg::*;
#(
  parameter int LINE_W = 12,
  parameter int WORDS  = 9,
  parameter int WIDX_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              send_wr,
  input  logic              send_arm,
  input  logic              send_any,
  input  logic [LINE_W-1:0] send_line,
  input  logic              blank_active,
  input  logic [LINE_W-1:0] line_cnt,
  input  logic [31:0]       rd_word,
  output logic [WIDX_W-1:0] rd_idx,
  input  logic              tx_ready,
  output logic [7:0]        tx_data,
  output logic              tx_valid,
  output logic              busy,
  output logic              armed,
  output logic              any_q,
  output logic [LINE_W-1:0] line_q
);
  localparam logic [WIDX_W-1:0] LAST_W = WIDX_W'(WORDS - 1);

  tx_state_e         state;
  logic [WIDX_W-1:0] widx;
  logic [1:0]        bidx;
  logic [31:0]       shreg;
  logic              launch;

  assign launch = armed && (state == TX_IDLE) && blank_active &&
                  (any_q || (line_cnt == line_q));

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= TX_IDLE;
      armed    <= 1'b0;
      any_q    <= 1'b0;
      line_q   <= '0;
      widx     <= '0;
      bidx     <= '0;
      shreg    <= '0;
      tx_valid <= 1'b0;
    end else begin
      if (send_wr) begin
        armed  <= send_arm;
        any_q  <= send_any;
        line_q <= send_line;
      end
      case (state)
        TX_IDLE: if (launch) begin
          widx  <= '0;
          state <= TX_RD;
        end
        TX_RD: state <= TX_LD;
        TX_LD: begin
          shreg    <= rd_word;
          bidx     <= '0;
          tx_valid <= 1'b1;
          state    <= TX_OUT;
        end
        TX_OUT: if (tx_ready) begin
          if (bidx == 2'd3) begin
            tx_valid <= 1'b0;
            if (widx == LAST_W) begin
              state <= TX_IDLE;
              armed <= 1'b0;
            end else begin
              widx  <= widx + WIDX_W'(1);
              state <= TX_RD;
            end
          end else begin
            shreg <= shreg >> 8;
            bidx  <= bidx + 2'd1;
          end
        end
        default: state <= TX_IDLE;
      endcase
    end
  end

  assign tx_data = shreg[7:0];
  assign busy    = (state != TX_IDLE);
  assign rd_idx  = widx;
endmodule

// File: rtl/sec_pkt_store.sv
module sec_pkt_store #(
  parameter int NUM_SLOTS = 8,
  parameter int TX_SLOT   = 4,
  parameter int PAY_WORDS = 8,
  parameter int LINE_W    = 12,
  localparam int SLOT_W   = $clog2(NUM_SLOTS),
  localparam int PIDX_W   = $clog2(PAY_WORDS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [SLOT_W-1:0]    sw_slot,
  input  logic                 sw_hdr_we,
  input  logic                 sw_pay_we,
  input  logic [PIDX_W-1:0]    sw_pay_idx,
  input  logic [31:0]          sw_wdata,
  input  logic                 sw_imm_commit,
  input  logic                 sw_frame_commit,
  input  logic                 sw_send_wr,
  input  logic                 sw_send_arm,
  input  logic                 sw_send_anyline,
  input  logic [LINE_W-1:0]    sw_send_line,
  input  logic                 sw_conflict_clr,
  input  logic                 frame_start,
  input  logic                 blank_active,
  input  logic [LINE_W-1:0]    line_cnt,
  input  logic                 tx_ready,
  output logic [7:0]           tx_data,
  output logic                 tx_valid,
  output logic                 send_pending,
  output logic [NUM_SLOTS-1:0] imm_pending,
  output logic [NUM_SLOTS-1:0] frame_pending,
  output logic                 conflict
);
  localparam int WORDS  = PAY_WORDS + 1;
  localparam int WIDX_W = $clog2(WORDS);
  localparam int AW     = SLOT_W + 1 + WIDX_W;
  localparam logic [SLOT_W-1:0] TXS = SLOT_W'(TX_SLOT);

  logic [NUM_SLOTS-1:0] bank;
  logic [WIDX_W-1:0]    wr_idx, rd_idx;
  logic [AW-1:0]        waddr, raddr;
  logic [31:0]          rd_word;
  logic                 wr_en, tx_busy, tx_armed, tx_any;
  logic [LINE_W-1:0]    tx_line;

  assign wr_en  = sw_hdr_we | sw_pay_we;
  assign wr_idx = sw_hdr_we ? '0 : (WIDX_W'(sw_pay_idx) + WIDX_W'(1));
  assign waddr  = {sw_slot, ~bank[sw_slot], wr_idx};
  assign raddr  = {TXS, bank[TX_SLOT], rd_idx};

  sec_pkt_ram #(.AW(AW), .DW(32)) u_ram (
    .clk   (clk),
    .we    (wr_en),
    .waddr (waddr),
    .wdata (sw_wdata),
    .raddr (raddr),
    .rdata (rd_word)
  );

  sec_pkt_commit #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) u_commit (
    .clk         (clk),
    .rst         (rst),
    .sel_slot    (sw_slot),
    .imm_req     (sw_imm_commit),
    .frame_req   (sw_frame_commit),
    .frame_start (frame_start),
    .rd_busy     (tx_busy),
    .rd_slot     (TXS),
    .bank        (bank),
    .imm_pend    (imm_pending),
    .frame_pend  (frame_pending)
  );

  sec_pkt_tx #(.LINE_W(LINE_W), .WORDS(WORDS), .WIDX_W(WIDX_W)) u_tx (
    .clk          (clk),
    .rst          (rst),
    .send_wr      (sw_send_wr),
    .send_arm     (sw_send_arm),
    .send_any     (sw_send_anyline),
    .send_line    (sw_send_line),
    .blank_active (blank_active),
    .line_cnt     (line_cnt),
    .rd_word      (rd_word),
    .rd_idx       (rd_idx),
    .tx_ready     (tx_ready),
    .tx_data      (tx_data),
    .tx_valid     (tx_valid),
    .busy         (tx_busy),
    .armed        (tx_armed),
    .any_q        (tx_any),
    .line_q       (tx_line)
  );

  always_ff @(posedge clk) begin
    if (rst)                                      conflict <= 1'b0;
    else if (wr_en && tx_busy && sw_slot == TXS)  conflict <= 1'b1;
    else if (sw_conflict_clr)                     conflict <= 1'b0;
  end

  assign send_pending = tx_armed | tx_busy;
endmodule

// File: rtl/sec_pkt_store_chk.sv
module sec_pkt_store_chk #(
  parameter int LINE_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic [7:0]        tx_data,
  input logic              conflict,
  input logic              sw_conflict_clr,
  input logic              send_pending,
  input logic              busy,
  input logic              bank_tx,
  input logic              imm_pend_tx,
  input logic              blank_active,
  input logic [LINE_W-1:0] line_cnt,
  input logic [LINE_W-1:0] line_q,
  input logic              any_q
);
  a_r1_reset_idle: assert property (@(posedge clk)
    $past(rst) |-> (!tx_valid && !conflict && !send_pending));

  a_r5_bank_frozen: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(bank_tx));

  a_r5_commit_after_read: assert property (@(posedge clk) disable iff (rst)
    (imm_pend_tx && !busy) |=> !imm_pend_tx);

  a_r6_hold_byte: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

  a_r7_quiet_unarmed: assert property (@(posedge clk) disable iff (rst)
    !send_pending |=> !tx_valid);

  a_r9_launch_gate: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> ($past(blank_active) &&
                     ($past(any_q) || ($past(line_cnt) == $past(line_q)))));

  a_r10_sticky: assert property (@(posedge clk) disable iff (rst)
    (conflict && !sw_conflict_clr) |=> conflict);
endmodule

bind sec_pkt_store sec_pkt_store_chk #(.LINE_W(LINE_W)) u_chk (
  .clk             (clk),
  .rst             (rst),
  .tx_valid        (tx_valid),
  .tx_ready        (tx_ready),
  .tx_data         (tx_data),
  .conflict        (conflict),
  .sw_conflict_clr (sw_conflict_clr),
  .send_pending    (send_pending),
  .busy            (tx_busy),
  .bank_tx         (bank[TX_SLOT]),
  .imm_pend_tx     (imm_pending[TX_SLOT]),
  .blank_active    (blank_active),
  .line_cnt        (line_cnt),
  .line_q          (tx_line),
  .any_q           (tx_any)
);

// File: tb/sec_pkt_store_test.sv
module sec_pkt_store_test;
  localparam int NS = 8;
  localparam int TS = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  sw_slot = '0;
  logic        sw_hdr_we = 0, sw_pay_we = 0;
  logic [2:0]  sw_pay_idx = '0;
  logic [31:0] sw_wdata = '0;
  logic        sw_imm_commit = 0, sw_frame_commit = 0;
  logic        sw_send_wr = 0, sw_send_arm = 0, sw_send_anyline = 0;
  logic [11:0] sw_send_line = '0;
  logic        sw_conflict_clr = 0, frame_start = 0, blank_active = 0;
  logic [11:0] line_cnt = '0;
  logic        tx_ready = 1'b1;
  logic [7:0]  tx_data;
  logic        tx_valid, send_pending, conflict;
  logic [NS-1:0] imm_pending, frame_pending;

  int nchk = 0, nbad = 0;
  logic [7:0] got [0:63];
  int ngot;
  bit finished = 0;

  always #5 clk = ~clk;

  sec_pkt_store uut (.*);

  localparam logic [31:0] HA = 32'h4433_2211, BA = 32'h1000_00A0;
  localparam logic [31:0] HB = 32'h0B0A_0908, BB = 32'h2222_1111;
  localparam logic [31:0] HC = 32'hC3C2_C1C0, BC = 32'h5A5A_0F0F;
  localparam logic [31:0] HD = 32'hD4D3_D2D1, BD = 32'h7654_3210;

  function automatic logic [31:0] pay_word(input logic [31:0] base, input int k);
    return base + 32'(k) * 32'h0403_0201;
  endfunction

  function automatic logic [7:0] exp_byte(input logic [31:0] hdr, input logic [31:0] base, input int i);
    logic [31:0] w;
    if (i < 4) return hdr[8*i +: 8];
    w = pay_word(base, (i - 4) / 4);
    return w[8*((i - 4) % 4) +: 8];
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_pkt(input logic [2:0] slot, input logic [31:0] hdr, input logic [31:0] base);
    @(negedge clk);
    sw_slot = slot; sw_hdr_we = 1; sw_wdata = hdr;
    @(negedge clk);
    sw_hdr_we = 0;
    for (int k = 0; k < 8; k++) begin
      sw_pay_we = 1; sw_pay_idx = 3'(k); sw_wdata = pay_word(base, k);
      @(negedge clk);
    end
    sw_pay_we = 0;
  endtask

  task automatic imm_commit(input logic [2:0] slot);
    @(negedge clk); sw_slot = slot; sw_imm_commit = 1;
    @(negedge clk); sw_imm_commit = 0;
  endtask

  task automatic arm(input bit any, input logic [11:0] line);
    @(negedge clk);
    sw_send_wr = 1; sw_send_arm = 1; sw_send_anyline = any; sw_send_line = line;
    @(negedge clk);
    sw_send_wr = 0;
  endtask

  // collects bytes until send_pending falls; mode 1 throttles tx_ready
  task automatic collect(input bit throttle, output int viol);
    int cnt = 0;
    bit pv = 0, pr = 0;
    logic [7:0] pd = '0;
    viol = 0; ngot = 0;
    while (send_pending && cnt < 600) begin
      if (pv && !pr && !(tx_valid && tx_data == pd)) viol++;
      if (tx_valid && tx_ready && ngot < 64) begin got[ngot] = tx_data; ngot++; end
      pv = tx_valid; pr = tx_ready; pd = tx_data;
      @(negedge clk); cnt++;
      tx_ready = throttle ? ((cnt % 3) != 0) : 1'b1;
    end
    tx_ready = 1'b1;
  endtask

  task automatic compare_pkt(input string tag, input logic [31:0] hdr, input logic [31:0] base);
    int bad = 0, first = -1;
    check(ngot == 36, {tag, " byte count"}, 32'(ngot), 32'd36);
    for (int i = 0; i < 36 && i < ngot; i++)
      if (got[i] !== exp_byte(hdr, base, i)) begin bad++; if (first < 0) first = i; end
    if (first < 0) check(1'b1, tag, 0, 0);
    else check(1'b0, {tag, " byte content"}, 32'(got[first]), 32'(exp_byte(hdr, base, first)));
  endtask

  task automatic send_any_and_compare(input string tag, input logic [31:0] hdr, input logic [31:0] base);
    int v;
    blank_active = 1;
    arm(1'b1, '0);
    collect(1'b0, v);
    compare_pkt(tag, hdr, base);
  endtask

  task automatic t_reset();
    check(!tx_valid, "R1 tx_valid", 32'(tx_valid), 0);
    check(!send_pending, "R1 send_pending", 32'(send_pending), 0);
    check(!conflict, "R1 conflict", 32'(conflict), 0);
    check(imm_pending == '0 && frame_pending == '0, "R1 pending flags",
          {imm_pending, frame_pending}, 0);
  endtask

  task automatic t_immediate();
    wr_pkt(3'(TS), HA, BA);
    imm_commit(3'(TS));
    check(imm_pending[TS] == 1'b0, "R3 no deferral when idle", 32'(imm_pending), 0);
    send_any_and_compare("R3 packet A after commit", HA, BA);
    check(!send_pending, "R6 pending cleared after last byte", 32'(send_pending), 0);
  endtask

  task automatic t_shadow();
    wr_pkt(3'(TS), HB, BB);
    send_any_and_compare("R2 uncommitted write invisible", HA, BA);
    imm_commit(3'(TS));
    send_any_and_compare("R3 packet B after commit", HB, BB);
  endtask

  task automatic t_frame();
    wr_pkt(3'(TS), HC, BC);
    @(negedge clk); sw_slot = 3'(TS); sw_frame_commit = 1;
    @(negedge clk); sw_frame_commit = 0;
    check(frame_pending[TS] == 1'b1, "R4 frame pending set", 32'(frame_pending), 32'h10);
    send_any_and_compare("R4 old packet before boundary", HB, BB);
    check(frame_pending[TS] == 1'b1, "R4 still pending", 32'(frame_pending), 32'h10);
    @(negedge clk); frame_start = 1;
    @(negedge clk); frame_start = 0;
    check(frame_pending[TS] == 1'b0, "R4 pending cleared", 32'(frame_pending), 0);
    send_any_and_compare("R4 new packet after boundary", HC, BC);
  endtask

  task automatic t_defer();
    int cnt = 0;
    wr_pkt(3'(TS), HD, BD);
    blank_active = 1;
    arm(1'b1, '0);
    ngot = 0;
    while (send_pending && cnt < 400) begin
      if (tx_valid && tx_ready && ngot < 64) begin got[ngot] = tx_data; ngot++; end
      sw_pay_we = 0; sw_imm_commit = 0;
      if (cnt == 11) check(!conflict, "R10 other slot no conflict", 32'(conflict), 0);
      if (cnt == 13) check(imm_pending[TS], "R5 commit deferred", 32'(imm_pending), 32'h10);
      if (cnt == 15) check(conflict, "R10 conflict raised", 32'(conflict), 1);
      if (cnt == 10) begin sw_slot = 3'd2; sw_pay_we = 1; sw_pay_idx = 0; sw_wdata = 32'hDEAD_BEEF; end
      if (cnt == 12) begin sw_slot = 3'(TS); sw_imm_commit = 1; end
      if (cnt == 14) begin sw_slot = 3'(TS); sw_pay_we = 1; sw_pay_idx = 0; sw_wdata = pay_word(BD, 0); end
      @(negedge clk); cnt++;
    end
    compare_pkt("R5 in-flight bytes are old packet", HC, BC);
    check(imm_pending[TS], "R5 pending through end of read", 32'(imm_pending), 32'h10);
    @(negedge clk);
    check(!imm_pending[TS], "R5 commit done one cycle later", 32'(imm_pending), 0);
    check(conflict, "R10 conflict sticky", 32'(conflict), 1);
    sw_conflict_clr = 1;
    @(negedge clk); sw_conflict_clr = 0;
    check(!conflict, "R10 conflict cleared", 32'(conflict), 0);
    send_any_and_compare("R5 deferred commit took effect", HD, BD);
  endtask

  task automatic t_backpressure();
    int v;
    blank_active = 1;
    arm(1'b1, '0);
    collect(1'b1, v);
    compare_pkt("R6 throttled packet", HD, BD);
    check(v == 0, "R6 byte held while not ready", 32'(v), 0);
  endtask

  task automatic t_cancel();
    int seen = 0;
    blank_active = 0;
    arm(1'b1, '0);
    check(send_pending, "R7 armed", 32'(send_pending), 1);
    @(negedge clk); sw_send_wr = 1; sw_send_arm = 0;
    @(negedge clk); sw_send_wr = 0;
    check(!send_pending, "R7 cancel clears pending", 32'(send_pending), 0);
    blank_active = 1;
    for (int i = 0; i < 20; i++) begin @(negedge clk); if (tx_valid) seen++; end
    check(seen == 0, "R7 no bytes after cancel", 32'(seen), 0);
  endtask

  task automatic t_anyline();
    int seen = 0, v;
    blank_active = 0; line_cnt = 12'd7;
    arm(1'b1, 12'd3);
    for (int i = 0; i < 15; i++) begin @(negedge clk); if (tx_valid) seen++; end
    check(seen == 0 && send_pending, "R8 no launch outside blanking", 32'(seen), 0);
    blank_active = 1;
    collect(1'b0, v);
    compare_pkt("R8 any-line launch in blanking", HD, BD);
  endtask

  task automatic t_line();
    int seen = 0, v;
    blank_active = 1; line_cnt = 12'd3;
    arm(1'b0, 12'd5);
    for (int i = 0; i < 15; i++) begin @(negedge clk); if (tx_valid) seen++; end
    check(seen == 0, "R9 wrong line no launch", 32'(seen), 0);
    blank_active = 0; line_cnt = 12'd5;
    for (int i = 0; i < 10; i++) begin @(negedge clk); if (tx_valid) seen++; end
    check(seen == 0 && send_pending, "R9 no launch outside blanking", 32'(seen), 0);
    blank_active = 1;
    collect(1'b0, v);
    compare_pkt("R9 launch at programmed line", HD, BD);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_immediate();
    t_shadow();
    t_frame();
    t_defer();
    t_backpressure();
    t_cancel();
    t_anyline();
    t_line();
    finished = 1;
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nchk++; nbad++;
      $display("FAIL watchdog expired act=1 exp=0");
      $display("test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  end
endmodule